// File: doc/BRIEF.md
# Segmentation Probability Mask Generator

This block sits behind a segmentation network and turns its per-pixel probabilities into three 8-bit output planes for one square patch at a time. Each input beat carries one pixel with two values: the probability that the pixel lies inside a droplet region, and the probability that it lies on a droplet boundary. The first output plane passes the boundary probability through unchanged. The second is a region mask. The third is a mask of separated regions, where the boundary probability is subtracted from the region probability before the threshold is applied. A negative difference never wraps.

Pixels arrive in raster order, with the column running fastest. The block counts columns and rows over a fixed patch of `PATCH_DIM` x `PATCH_DIM` pixels, which is 128 x 128 by default. It marks the first and last pixel of every patch on the output beat. Patches follow one another with no gap, and the counter restarts on its own after each last pixel. Adjacent patches overlap by half on the source image, so their origins are 64 pixels apart. Stitching the overlapping patches back together happens outside this block.

Both sides use valid/ready handshakes. A beat moves when valid and ready are high on the same rising edge. The block has a single output register stage. While that stage holds a beat the consumer has not taken, the stage freezes and input ready stays low. Input ready is high whenever the stage is empty or is being drained in the current cycle, so a full stream runs at one pixel per clock.

Top module: `segmask_gen`

## Requirements
- R1: `out_prob` of an output beat equals `in_boundary` of the input beat that produced it.
- R2: `out_region` is 8'hFF when the region probability is at least 128 (one half on the 8-bit scale), and 8'h00 otherwise.
- R3: `out_sep` is 8'hFF when the region probability is at least the boundary probability and their difference is at least 128. It is 8'h00 otherwise. When the boundary probability is the larger one, the result is 8'h00 with no modular wraparound, so (0,128) gives 8'h00.
- R4: `out_first` is high exactly on the beat of pixel index 0 of each patch. The index is row*PATCH_DIM+col.
- R5: `out_last` is high exactly on the beat of pixel index PATCH_DIM*PATCH_DIM-1 (16383 by default). The next accepted pixel has index 0.
- R6: The column and row counters advance only on accepted input beats. Cycles spent stalled do not advance them.
- R7: While `out_valid` is high and `out_ready` is low, every output holds its value.
- R8: `in_ready` is low only while the output stage holds a beat and `out_ready` is low.
- R9: During and right after reset, `out_valid` is 0, `in_ready` is 1, and the next accepted pixel has index 0.
- R10: An input beat accepted on a rising edge appears on the outputs with `out_valid` high right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts an input beat |
| in_region | input | PIX_W | Region probability of the pixel |
| in_boundary | input | PIX_W | Boundary probability of the pixel |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_prob | output | PIX_W | Boundary probability, passed through |
| out_region | output | PIX_W | Region mask, all ones or zero |
| out_sep | output | PIX_W | Separated-region mask, all ones or zero |
| out_first | output | 1 | Beat is the first pixel of a patch |
| out_last | output | 1 | Beat is the last pixel of a patch |

## Verification
The last pixel of a patch can be caught in a stall with the first pixel of the next patch waiting behind it. When the stall ends, the patch-end beat is drained and the patch-start beat is loaded on the same edge. The bench provokes this by streaming a complete patch and then dropping `out_ready` just as pixel 16383 is loaded, holding it low for several cycles. It judges the result by three things: the held beat stays frozen with `in_ready` low, the stall cycles do not move the counter, and the beat that follows carries `out_first` with the correct mask values.

// File: rtl/segmask_pkg.sv
package segmask_pkg;
  localparam int unsigned PIX_W_DEF     = 8;
  localparam int unsigned PATCH_DIM_DEF = 128;

  // Mask byte: all ones when set, all zeros when clear.
  function automatic logic [PIX_W_DEF-1:0] mask_byte(input logic hit);
    return hit ? {PIX_W_DEF{1'b1}} : '0;
  endfunction
endpackage

// File: rtl/segmask_classify.sv
module segmask_classify #(
  parameter int unsigned PIX_W = segmask_pkg::PIX_W_DEF
) (
  input  logic [PIX_W-1:0] region_p,
  input  logic [PIX_W-1:0] boundary_p,
  output logic [PIX_W-1:0] prob_o,
  output logic [PIX_W-1:0] region_o,
  output logic [PIX_W-1:0] sep_o
);
  localparam logic [PIX_W:0] HALF = {2'b01, {(PIX_W-1){1'b0}}};

  logic [PIX_W:0] diff;
  logic           borrow;
  logic           region_hit;
  logic           sep_hit;

  always_comb begin
    diff       = {1'b0, region_p} - {1'b0, boundary_p};
    borrow     = diff[PIX_W];
    region_hit = ({1'b0, region_p} >= HALF);
    sep_hit    = !borrow && (diff >= HALF);
    prob_o     = boundary_p;
    region_o   = region_hit ? {PIX_W{1'b1}} : '0;
    sep_o      = sep_hit ? {PIX_W{1'b1}} : '0;
  end
endmodule

// File: rtl/segmask_raster.sv
module segmask_raster #(
  parameter int unsigned PATCH_DIM = segmask_pkg::PATCH_DIM_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic at_first,
  output logic at_last
);
  localparam int unsigned CW = (PATCH_DIM > 1) ? $clog2(PATCH_DIM) : 1;
  localparam logic [CW-1:0] LIM = CW'(PATCH_DIM - 1);

  logic [CW-1:0] col_q;
  logic [CW-1:0] row_q;
  logic          col_end;
  logic          row_end;

  assign col_end  = (col_q == LIM);
  assign row_end  = (row_q == LIM);
  assign at_first = (col_q == '0) && (row_q == '0);
  assign at_last  = col_end && row_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (step) begin
      if (col_end) begin
        col_q <= '0;
        row_q <= row_end ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/segmask_outreg.sv
module segmask_outreg #(
  parameter int unsigned PIX_W = segmask_pkg::PIX_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             drain,
  input  logic [PIX_W-1:0] prob_d,
  input  logic [PIX_W-1:0] region_d,
  input  logic [PIX_W-1:0] sep_d,
  input  logic             first_d,
  input  logic             last_d,
  output logic             valid_q,
  output logic [PIX_W-1:0] prob_q,
  output logic [PIX_W-1:0] region_q,
  output logic [PIX_W-1:0] sep_q,
  output logic             first_q,
  output logic             last_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
    end else if (drain) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prob_q   <= '0;
      region_q <= '0;
      sep_q    <= '0;
      first_q  <= 1'b0;
      last_q   <= 1'b0;
    end else if (load) begin
      prob_q   <= prob_d;
      region_q <= region_d;
      sep_q    <= sep_d;
      first_q  <= first_d;
      last_q   <= last_d;
    end
  end
endmodule

// File: rtl/segmask_gen.sv
module segmask_gen #(
  parameter int unsigned PIX_W     = segmask_pkg::PIX_W_DEF,
  parameter int unsigned PATCH_DIM = segmask_pkg::PATCH_DIM_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_region,
  input  logic [PIX_W-1:0] in_boundary,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_prob,
  output logic [PIX_W-1:0] out_region,
  output logic [PIX_W-1:0] out_sep,
  output logic             out_first,
  output logic             out_last
);
  logic             accept;
  logic             drain;
  logic [PIX_W-1:0] c_prob;
  logic [PIX_W-1:0] c_region;
  logic [PIX_W-1:0] c_sep;
  logic             c_first;
  logic             c_last;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign drain    = out_valid && out_ready;

  segmask_classify #(.PIX_W(PIX_W)) classify_i (
    .region_p  (in_region),
    .boundary_p(in_boundary),
    .prob_o    (c_prob),
    .region_o  (c_region),
    .sep_o     (c_sep)
  );

  segmask_raster #(.PATCH_DIM(PATCH_DIM)) raster_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (accept),
    .at_first(c_first),
    .at_last (c_last)
  );

  segmask_outreg #(.PIX_W(PIX_W)) outreg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .drain   (drain),
    .prob_d  (c_prob),
    .region_d(c_region),
    .sep_d   (c_sep),
    .first_d (c_first),
    .last_d  (c_last),
    .valid_q (out_valid),
    .prob_q  (out_prob),
    .region_q(out_region),
    .sep_q   (out_sep),
    .first_q (out_first),
    .last_q  (out_last)
  );
endmodule

// File: rtl/segmask_gen_chk.sv
module segmask_gen_chk #(
  parameter int unsigned PIX_W     = segmask_pkg::PIX_W_DEF,
  parameter int unsigned PATCH_DIM = segmask_pkg::PATCH_DIM_DEF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PIX_W-1:0] in_region,
  input logic [PIX_W-1:0] in_boundary,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_prob,
  input logic [PIX_W-1:0] out_region,
  input logic [PIX_W-1:0] out_sep,
  input logic             out_first,
  input logic             out_last
);
  localparam logic [PIX_W-1:0] HALF = {1'b1, {(PIX_W-1){1'b0}}};

  // R10
  load_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R1
  prob_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_prob == $past(in_boundary)));

  // R2
  region_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_region >= HALF)) |=> (out_region == {PIX_W{1'b1}}));

  // R3
  sep_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_boundary > in_region)) |=> (out_sep == '0));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prob) && $stable(out_region)
                                   && $stable(out_sep) && $stable(out_first) && $stable(out_last)));

  // R8
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R4
  marks_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_first, out_last}));
endmodule

bind segmask_gen segmask_gen_chk #(.PIX_W(PIX_W), .PATCH_DIM(PATCH_DIM)) chk_i (.*);

// File: tb/segmask_gen_tb_top.sv
`timescale 1ns/1ps
module segmask_gen_tb_top;
  localparam int DIM  = 128;
  localparam int NPIX = DIM * DIM;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_region = '0;
  logic [7:0] in_boundary = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_prob, out_region, out_sep;
  logic       out_first, out_last;

  int checks = 0;
  int fails  = 0;
  int pix    = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  segmask_gen dut_i (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_reg(input int r);
    return (r >= 128) ? 255 : 0;
  endfunction

  function automatic int exp_sep(input int r, input int b);
    return (r >= b && (r - b) >= 128) ? 255 : 0;
  endfunction

  task automatic check_beat(input int r, input int b, input int idx);
    chk("R10 out_valid", out_valid, 1);
    chk("R1 out_prob", out_prob, b);
    chk("R2 out_region", out_region, exp_reg(r));
    chk("R3 out_sep", out_sep, exp_sep(r, b));
    chk("R4 out_first", out_first, (idx == 0) ? 1 : 0);
    chk("R5 out_last", out_last, (idx == NPIX - 1) ? 1 : 0);
  endtask

  // Drive one beat at a falling edge; out_ready high, so accepted next edge.
  task automatic send_check(input int r, input int b);
    in_region = 8'(r); in_boundary = 8'(b); in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check_beat(r, b, pix);
    pix = (pix + 1) % NPIX;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 out_valid in reset", out_valid, 0);
    chk("R9 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 out_valid after reset", out_valid, 0);
    pix = 0;
  endtask

  task automatic t_thresholds;
    send_check(127, 0);
    send_check(128, 0);
    send_check(255, 255);
    send_check(200, 72);
    send_check(200, 73);
    send_check(0, 128);
    send_check(100, 228);
    send_check(10, 200);
    send_check(255, 127);
  endtask

  task automatic t_patch_fill;
    int seed = 7;
    while (pix != NPIX - 1) begin
      send_check($urandom(seed) % 256, $urandom % 256);
    end
  endtask

  // Last pixel of a patch stalled, first pixel of the next waiting behind it.
  task automatic t_stall_at_wrap;
    @(negedge clk);
    chk("R10 drained", out_valid, 0);
    out_ready = 1'b0;
    in_region = 8'd250; in_boundary = 8'd20; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    check_beat(250, 20, NPIX - 1);
    in_region = 8'd130; in_boundary = 8'd2;
    chk("R8 in_ready low while held", in_ready, 0);
    repeat (4) @(negedge clk);
    chk("R7 held last", out_last, 1);
    chk("R7 held prob", out_prob, 20);
    chk("R8 in_ready still low", in_ready, 0);
    out_ready = 1'b1;
    #0.5;
    chk("R8 in_ready with out_ready", in_ready, 1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check_beat(130, 2, 0);
    chk("R6 first after stall", out_first, 1);
    pix = 1;
    send_check(64, 200);
    send_check(128, 0);
  endtask

  initial begin
    t_reset();
    t_thresholds();
    t_patch_fill();
    t_stall_at_wrap();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule